// File: doc/BRIEF.md
# EPROM Programming Pulse Sequencer

This block sits on the programming host and writes a single byte into a one-time-programmable microcontroller. A one-cycle start command carries a target address, a data byte and an operation mode: code byte, encryption-table byte, first lock bit or second lock bit. Once the command is accepted, the block drives the address and data buses and the six mode-select lines. It raises the programming-voltage enable and issues a fixed burst of active-low programming pulses, with setup and hold windows placed around that burst.

All timing is counted in clock cycles. The block's clock frequency, the target's oscillator frequency and the microsecond and oscillator-period figures are parameters. The pulse count, the pulse low and high lengths, the voltage lead and trail, and the bus setup and hold lengths are derived from them. After the sequence ends, a one-cycle completion pulse marks that the next byte may be issued. The voltage source, the target's memory array and verify read-back are handled elsewhere.

Top module: `prg_pulse_gen`

## Requirements
- R1: While reset is held, and until a command is accepted, prog_n_o is 1, vpp_en_o is 0, busy_o is 0, done_o is 0 and ctl_o is 0.
- R2: Every accepted command produces exactly PULSE_COUNT low pulses on prog_n_o (25 by default).
- R3: Every low pulse lasts LOW_US microseconds of clock cycles (100 µs by default).
- R4: Between consecutive low pulses, prog_n_o stays high for exactly GAP_US microseconds of clock cycles (10 µs by default).
- R5: addr_o and data_o take the command's values in the cycle busy_o rises and stay unchanged until busy_o falls. The first falling edge of prog_n_o comes at least SETUP_OSC target oscillator periods (48) after busy_o rises. busy_o falls at least that many periods after the last rising edge.
- R6: vpp_en_o rises VPP_US microseconds (10 µs) before the first falling edge of prog_n_o and falls VPP_US after the last rising edge. prog_n_o is never low while vpp_en_o is low.
- R7: While busy_o is high, ctl_o = {reset, store-enable, P2.7, P2.6, P3.7, P3.6} carries the selected mode. mode 0 (code) gives 6'b101011, mode 1 (encryption) gives 6'b101010, mode 2 (lock 1) gives 6'b101111 and mode 3 (lock 2) gives 6'b101100. While idle, ctl_o is 0.
- R8: busy_o rises in the cycle after an accepted start and falls at the end of the hold window. done_o is high for exactly one cycle, in the first cycle busy_o is low.
- R9: A start asserted while busy_o is high is ignored. Buses, mode lines and pulse count continue unchanged.
- R10: An encryption-mode command (mode 1) whose address is above ENC_LAST (1Fh) is rejected. busy_o stays low, no pulse is issued and addr_o keeps its previous value. Address 1Fh itself is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle command strobe |
| mode_i | input | 2 | Operation: 0 code, 1 encryption, 2 lock 1, 3 lock 2 |
| addr_i | input | ADDR_W | Target address |
| data_i | input | DATA_W | Byte to program |
| addr_o | output | ADDR_W | Address bus to the target |
| data_o | output | DATA_W | Data bus to the target |
| ctl_o | output | 6 | Mode-select lines |
| vpp_en_o | output | 1 | Programming-voltage enable |
| prog_n_o | output | 1 | Active-low programming pulse |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with CLK_FREQ_HZ set to 1 MHz and OSC_FREQ_HZ set to 4 MHz. One cycle is then one microsecond, so a full 25-pulse burst takes under 3000 cycles, while the pulse count and microsecond figures keep their default values. The 48-period setup and hold windows shrink to 12 cycles and stay distinct from the 10-cycle voltage lead. This makes every pulse width, every gap and each window boundary measurable exactly for all four modes. It also leaves room for the rejected-address and mid-burst restart cases.

// File: rtl/prg_pkg.sv
package prg_pkg;

  typedef enum logic [1:0] {
    PM_CODE  = 2'd0,
    PM_ENC   = 2'd1,
    PM_LOCK1 = 2'd2,
    PM_LOCK2 = 2'd3
  } prg_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_LEAD  = 3'd2,
    ST_LOW   = 3'd3,
    ST_GAP   = 3'd4,
    ST_TRAIL = 3'd5,
    ST_HOLD  = 3'd6
  } prg_state_e;

  localparam int CTL_W = 6;

endpackage

// File: rtl/prg_timer.sv
module prg_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);

  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)              cnt_d = load_val;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/prg_mode_map.sv
module prg_mode_map
  import prg_pkg::*;
(
  input  prg_mode_e         mode,
  input  logic              active,
  output logic [CTL_W-1:0]  ctl
);

  // bit order: reset, store-enable, P2.7, P2.6, P3.7, P3.6
  always_comb begin
    ctl = '0;
    if (active) begin
      unique case (mode)
        PM_CODE:  ctl = 6'b101011;
        PM_ENC:   ctl = 6'b101010;
        PM_LOCK1: ctl = 6'b101111;
        PM_LOCK2: ctl = 6'b101100;
        default:  ctl = '0;
      endcase
    end
  end

endmodule

// File: rtl/prg_seq.sv
module prg_seq
  import prg_pkg::*;
#(
  parameter int TW          = 8,
  parameter int PULSE_COUNT = 25,
  parameter int S_CYC       = 12,
  parameter int L_CYC       = 10,
  parameter int P_CYC       = 100,
  parameter int G_CYC       = 10,
  parameter int H_CYC       = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          tmr_expired,
  output logic          tmr_load,
  output logic [TW-1:0] tmr_val,
  output prg_state_e    state,
  output logic          done
);

  localparam int IW = $clog2(PULSE_COUNT + 1);

  prg_state_e    st_q, st_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          done_q, done_d;

  always_comb begin
    st_d     = st_q;
    idx_d    = idx_q;
    done_d   = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (st_q)
      ST_IDLE: if (go) begin
        st_d = ST_SETUP; idx_d = '0; tmr_load = 1'b1; tmr_val = TW'(S_CYC - 1);
      end
      ST_SETUP: if (tmr_expired) begin
        st_d = ST_LEAD; tmr_load = 1'b1; tmr_val = TW'(L_CYC - 1);
      end
      ST_LEAD: if (tmr_expired) begin
        st_d = ST_LOW; tmr_load = 1'b1; tmr_val = TW'(P_CYC - 1);
      end
      ST_LOW: if (tmr_expired) begin
        idx_d    = idx_q + 1'b1;
        tmr_load = 1'b1;
        if (idx_q == IW'(PULSE_COUNT - 1)) begin
          st_d = ST_TRAIL; tmr_val = TW'(L_CYC - 1);
        end else begin
          st_d = ST_GAP;   tmr_val = TW'(G_CYC - 1);
        end
      end
      ST_GAP: if (tmr_expired) begin
        st_d = ST_LOW; tmr_load = 1'b1; tmr_val = TW'(P_CYC - 1);
      end
      ST_TRAIL: if (tmr_expired) begin
        st_d = ST_HOLD; tmr_load = 1'b1; tmr_val = TW'(H_CYC - 1);
      end
      ST_HOLD: if (tmr_expired) begin
        st_d = ST_IDLE; done_d = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      done_q <= done_d;
    end
  end

  assign state = st_q;
  assign done  = done_q;

  // checker counters, independent of the timer
  logic [TW-1:0] lo_run, gap_run;
  logic [IW-1:0] seen;
  logic          was_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_run  <= '0;
      gap_run <= '0;
      seen    <= '0;
      was_low <= 1'b0;
    end else begin
      lo_run  <= (st_q == ST_LOW) ? lo_run + 1'b1 : '0;
      gap_run <= (st_q == ST_GAP) ? gap_run + 1'b1 : '0;
      was_low <= (st_q == ST_LOW);
      if (st_q == ST_IDLE)                seen <= '0;
      else if (st_q == ST_LOW && !was_low) seen <= seen + 1'b1;
    end
  end

  assert_low_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LOW && tmr_expired) |-> lo_run == TW'(P_CYC - 1));

  assert_gap_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_GAP && tmr_expired) |-> gap_run == TW'(G_CYC - 1));

  assert_pulse_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_TRAIL && was_low) |-> seen == IW'(PULSE_COUNT));

endmodule

// File: rtl/prg_pulse_gen.sv
module prg_pulse_gen
  import prg_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int CLK_FREQ_HZ = 100_000_000,
  parameter int OSC_FREQ_HZ = 4_000_000,
  parameter int PULSE_COUNT = 25,
  parameter int LOW_US      = 100,
  parameter int GAP_US      = 10,
  parameter int VPP_US      = 10,
  parameter int SETUP_OSC   = 48,
  parameter int ENC_LAST    = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic [5:0]        ctl_o,
  output logic              vpp_en_o,
  output logic              prog_n_o,
  output logic              busy_o,
  output logic              done_o
);

  localparam int CYC_PER_US = CLK_FREQ_HZ / 1_000_000;
  localparam longint OSC_PROD = longint'(SETUP_OSC) * longint'(CLK_FREQ_HZ);
  localparam int WIN_CYC  = int'((OSC_PROD + longint'(OSC_FREQ_HZ) - 1) / longint'(OSC_FREQ_HZ));
  localparam int S_CYC    = (WIN_CYC < 1) ? 1 : WIN_CYC;
  localparam int P_CYC    = LOW_US * CYC_PER_US;
  localparam int G_CYC    = GAP_US * CYC_PER_US;
  localparam int L_CYC    = VPP_US * CYC_PER_US;
  localparam int H_CYC    = S_CYC;
  localparam int MAX_A    = (P_CYC > G_CYC) ? P_CYC : G_CYC;
  localparam int MAX_B    = (L_CYC > S_CYC) ? L_CYC : S_CYC;
  localparam int MAX_CYC  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int TW       = $clog2(MAX_CYC + 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  logic rst_n_s;
  assign rst_n_s = rst_sync[1];

  prg_state_e    state;
  logic          tmr_load, tmr_expired, seq_done;
  logic [TW-1:0] tmr_val;
  logic          idle, enc_bad, accept;

  assign idle    = (state == ST_IDLE);
  assign enc_bad = (prg_mode_e'(mode_i) == PM_ENC) && (addr_i > ADDR_W'(ENC_LAST));
  assign accept  = start_i && idle && !enc_bad;

  // command capture, enabled only on acceptance
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] data_q, data_d;
  prg_mode_e         mode_q, mode_d;

  always_comb begin
    addr_d = addr_q;
    data_d = data_q;
    mode_d = mode_q;
    if (accept) begin
      addr_d = addr_i;
      data_d = data_i;
      mode_d = prg_mode_e'(mode_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      addr_q <= '0;
      data_q <= '0;
      mode_q <= PM_CODE;
    end else begin
      addr_q <= addr_d;
      data_q <= data_d;
      mode_q <= mode_d;
    end
  end

  prg_timer #(.TW(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  prg_seq #(
    .TW(TW), .PULSE_COUNT(PULSE_COUNT), .S_CYC(S_CYC), .L_CYC(L_CYC),
    .P_CYC(P_CYC), .G_CYC(G_CYC), .H_CYC(H_CYC)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .go          (accept),
    .tmr_expired (tmr_expired),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val),
    .state       (state),
    .done        (seq_done)
  );

  prg_mode_map u_map (
    .mode   (mode_q),
    .active (!idle),
    .ctl    (ctl_o)
  );

  assign addr_o   = addr_q;
  assign data_o   = data_q;
  assign busy_o   = !idle;
  assign prog_n_o = (state != ST_LOW);
  assign vpp_en_o = (state == ST_LEAD) || (state == ST_LOW) ||
                    (state == ST_GAP)  || (state == ST_TRAIL);
  assign done_o   = seq_done;

  assert_prog_needs_vpp_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    !prog_n_o |-> vpp_en_o);

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    done_o |=> !done_o);

  assert_done_after_busy_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    done_o |-> !busy_o && $past(busy_o));

  assert_bus_hold_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (busy_o && $past(busy_o)) |-> ($stable(addr_o) && $stable(data_o)));

  assert_ctl_idle_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    !busy_o |-> ctl_o == '0);

  assert_enc_range_R10: assert property (@(posedge clk) disable iff (!rst_n_s)
    (busy_o && mode_q == PM_ENC) |-> addr_q <= ADDR_W'(ENC_LAST));

endmodule

// File: tb/prg_pulse_gen_bench.sv
module prg_pulse_gen_bench;

  localparam int CLK_HZ = 1_000_000;
  localparam int OSC_HZ = 4_000_000;
  localparam int N  = 25;
  localparam int P  = 100;
  localparam int G  = 10;
  localparam int L  = 10;
  localparam int S  = (48 * (CLK_HZ / 1000) + (OSC_HZ / 1000) - 1) / (OSC_HZ / 1000);
  localparam int H  = S;
  localparam int TOTAL = S + L + N*P + (N-1)*G + L + H;

  logic        clk, rst_n, start_i;
  logic [1:0]  mode_i;
  logic [15:0] addr_i, addr_o;
  logic [7:0]  data_i, data_o;
  logic [5:0]  ctl_o;
  logic        vpp_en_o, prog_n_o, busy_o, done_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  prg_pulse_gen #(.CLK_FREQ_HZ(CLK_HZ), .OSC_FREQ_HZ(OSC_HZ)) u_prg_pulse_gen (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .addr_i(addr_i), .data_i(data_i), .addr_o(addr_o), .data_o(data_o),
    .ctl_o(ctl_o), .vpp_en_o(vpp_en_o), .prog_n_o(prog_n_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: act %0d cycles exp < 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: act %0h exp %0h", req, what, act, exp);
    end
  endtask

  task automatic test_reset();
    rst_n = 1'b0; start_i = 1'b0; mode_i = 2'd0; addr_i = '0; data_i = '0;
    repeat (3) @(negedge clk);
    check(prog_n_o == 1'b1 && vpp_en_o == 1'b0, "R1", "prog/vpp in reset",
          {prog_n_o, vpp_en_o}, 2'b10);
    check(busy_o == 1'b0 && done_o == 1'b0 && ctl_o == 6'd0, "R1", "busy/done/ctl in reset",
          {busy_o, done_o, ctl_o}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(busy_o == 1'b0 && prog_n_o == 1'b1 && ctl_o == 6'd0, "R1", "idle after release",
          {busy_o, prog_n_o, ctl_o}, 8'h40);
  endtask

  task automatic run_op(input string name, input logic [1:0] md, input logic [15:0] a,
                        input logic [7:0] d, input logic [5:0] exp_ctl, input int poke_at);
    int falls = 0, rises = 0, first_fall = -1, last_fall = 0, last_rise = 0;
    int vpp_rise = -1, vpp_fall = -1, busy_fall = -1, done_cnt = 0;
    bit prev_p = 1'b1, prev_v = 1'b0;
    bit bad_low = 0, bad_gap = 0, bad_bus = 0, bad_ctl = 0, bad_vpp = 0, bad_done = 0;
    $display("-- %s", name);
    start_i = 1'b1; mode_i = md; addr_i = a; data_i = d;
    @(negedge clk);
    start_i = 1'b0;
    for (int t = 0; t < 6000; t++) begin
      if (prev_p && !prog_n_o) begin
        falls++;
        if (falls == 1) first_fall = t;
        else if (t - last_rise != G) bad_gap = 1;
        last_fall = t;
      end
      if (!prev_p && prog_n_o) begin
        rises++;
        if (t - last_fall != P) bad_low = 1;
        last_rise = t;
      end
      if (vpp_en_o && !prev_v && vpp_rise < 0) vpp_rise = t;
      if (!vpp_en_o && prev_v) vpp_fall = t;
      if (!prog_n_o && !vpp_en_o) bad_vpp = 1;
      if (busy_o) begin
        if (busy_fall >= 0) bad_done = 1;
        if (addr_o != a || data_o != d) bad_bus = 1;
        if (ctl_o != exp_ctl) bad_ctl = 1;
      end else begin
        if (ctl_o != 6'd0) bad_ctl = 1;
        if (busy_fall < 0) busy_fall = t;
      end
      if (done_o) begin
        done_cnt++;
        if (t != busy_fall) bad_done = 1;
      end
      prev_p = prog_n_o; prev_v = vpp_en_o;
      if (t == poke_at) begin
        start_i = 1'b1; mode_i = ~md; addr_i = ~a; data_i = ~d;
      end else if (t == poke_at + 1) begin
        start_i = 1'b0; mode_i = md; addr_i = a; data_i = d;
      end
      if (busy_fall >= 0 && t >= busy_fall + 3) break;
      @(negedge clk);
    end
    check(falls == N && rises == N, "R2", "pulse count", falls, N);
    check(!bad_low, "R3", "low width", last_rise - last_fall, P);
    check(!bad_gap, "R4", "gap width", bad_gap, 0);
    check(vpp_rise == S, "R6", "vpp lead start", vpp_rise, S);
    check(first_fall - vpp_rise == L, "R6", "vpp lead length", first_fall - vpp_rise, L);
    check(vpp_fall - last_rise == L, "R6", "vpp trail", vpp_fall - last_rise, L);
    check(!bad_vpp, "R6", "prog low without vpp", bad_vpp, 0);
    check(first_fall == S + L, "R5", "setup window", first_fall, S + L);
    check(busy_fall - last_rise == L + H, "R5", "hold window", busy_fall - last_rise, L + H);
    check(!bad_bus, "R5", "bus stable", bad_bus, 0);
    check(!bad_ctl, "R7", "mode lines", bad_ctl, 0);
    check(busy_fall == TOTAL, "R8", "busy length", busy_fall, TOTAL);
    check(done_cnt == 1 && !bad_done, "R8", "done pulse", done_cnt, 1);
    if (poke_at >= 0)
      check(!bad_bus && falls == N, "R9", "start while busy ignored", falls, N);
  endtask

  task automatic test_reject();
    logic [15:0] prev_a;
    bit bad = 0;
    prev_a = addr_o;
    $display("-- encryption address out of range");
    start_i = 1'b1; mode_i = 2'd1; addr_i = 16'h0020; data_i = 8'h77;
    @(negedge clk);
    start_i = 1'b0;
    for (int t = 0; t < 20; t++) begin
      if (busy_o || !prog_n_o || vpp_en_o || done_o) bad = 1;
      @(negedge clk);
    end
    check(!bad, "R10", "no activity for address 20h", bad, 0);
    check(addr_o == prev_a, "R10", "address not captured", addr_o, prev_a);
  endtask

  initial begin
    test_reset();
    run_op("code byte",          2'd0, 16'h1234, 8'hA5, 6'b101011, -1);
    run_op("encryption at 1Fh",  2'd1, 16'h001F, 8'h3C, 6'b101010, -1);
    test_reject();
    run_op("lock bit 1",         2'd2, 16'h0000, 8'hFF, 6'b101111, 500);
    run_op("lock bit 2",         2'd3, 16'h0BEE, 8'h01, 6'b101100, 5);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule